// File: doc/BRIEF.md
# Receive Resource Ring Fetcher

This block walks a circular table of receive buffer descriptors held in system memory. Each descriptor is four 16-bit fields: the low and high halves of a buffer start address, then the low and high halves of that buffer's size in 16-bit words. When a fetch is requested, the block reads the four fields one word at a time through a simple request/valid memory port. It places them in a 32-bit buffer-address output and a 32-bit word-count output. It then steps the ring's read pointer past the descriptor.

The ring is described by three 16-bit pointers supplied by the surrounding register file: start, end and write. A 16-bit upper-address input supplies the high half of every memory address. The read pointer belongs to this block, and the host may load it while the block is idle. After each step, the block wraps the read pointer to the start when it lands exactly on the end. It raises a sticky "ring exhausted" flag when the read pointer lands exactly on the write pointer. The host clears the flag with a clear pulse, and that clear also starts a new fetch. Incoming frames are accepted only while the receiver is enabled and the flag is low.

A mode input selects the descriptor layout. In the narrow layout the fields sit in consecutive 16-bit slots. In the wide layout each field sits in a 32-bit slot whose low half carries the value.

Top module: `rx_ring_fetch`

## Requirements
- R1: After synchronous reset, rd_ptr, buf_addr, buf_words, mem_addr are zero and busy, done, mem_req, exhausted are low.
- R2: Field k (k = 0..3) is read at address {upper_addr, rd_ptr + k*slot} where slot is 2 bytes when wide_mode=0 and 4 bytes when wide_mode=1, the low half computed modulo 2^16; mem_addr bit 0 is always 0.
- R3: The words returned for fields 0,1,2,3 appear as buf_addr = {field1, field0} and buf_words = {field3, field2}, taken from mem_rdata (the low 16 bits of each slot).
- R4: A completed fetch advances rd_ptr by 8 when wide_mode=0 and by 16 when wide_mode=1 (modulo 2^16).
- R5: If the advanced pointer equals ring_end (bit 0 ignored), rd_ptr is loaded with ring_start (bit 0 cleared) instead.
- R6: If the final rd_ptr of a fetch equals wr_ptr (bit 0 ignored), exhausted is set; it stays set through further fetches until cleared.
- R7: done pulses high for exactly one cycle, in the same cycle that busy falls and the new rd_ptr and exhausted values are first visible.
- R8: While busy is high, fetch_cmd, exh_clr and rp_wr have no effect: no extra fetch is queued and rd_ptr is not loaded.
- R9: An exh_clr pulse while idle and exhausted clears exhausted and starts a fetch; while idle and not exhausted it has no effect.
- R10: rx_ok is high exactly when rx_en is high and exhausted is low.
- R11: A host load through rp_wr stores rp_wdata with bit 0 forced to 0.
- R12: mem_req stays high with mem_addr unchanged until mem_rvalid is seen; a field is taken only in a cycle where mem_req and mem_rvalid are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_cmd | input | 1 | Request one descriptor fetch (pulse) |
| exh_clr | input | 1 | Host clears the exhausted flag; restarts fetching if it was set |
| rx_en | input | 1 | Receiver enabled |
| wide_mode | input | 1 | 0: 16-bit descriptor slots, 1: 32-bit slots |
| upper_addr | input | 16 | High half of all descriptor addresses |
| ring_start | input | 16 | Ring start pointer |
| ring_end | input | 16 | Ring end pointer (one past the last descriptor) |
| wr_ptr | input | 16 | Ring write pointer maintained by the host |
| rp_wr | input | 1 | Load the read pointer |
| rp_wdata | input | 16 | Value for a read-pointer load |
| mem_rvalid | input | 1 | Read data valid for the current request |
| mem_rdata | input | 16 | Read data |
| mem_req | output | 1 | Read request, held until mem_rvalid |
| mem_addr | output | 32 | Byte address of the read |
| rd_ptr | output | 16 | Current ring read pointer |
| buf_addr | output | 32 | Fetched buffer start address |
| buf_words | output | 32 | Fetched buffer size in words |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| exhausted | output | 1 | Ring exhausted flag |
| rx_ok | output | 1 | Reception permitted |

## Verification
The hardest state to reach is the one where the wrap and the exhaustion compare meet. The pointer must land on the end and be reloaded from the start, and the reloaded value must then be checked against the write pointer. This happens in a run that first exhausts the ring and then relies on the clear pulse as the only trigger. The bench places the write pointer one descriptor before the end, so that six back-to-back fetches per bus width pass through exhaustion, clear-restart and wrap in turn. The memory model varies its latency from fetch to fetch, so that the fields are taken only on their valid cycles.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned IDX_W      = $clog2(NUM_FIELDS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_ADV  = 2'd2
  } rrf_state_e;
endpackage

// File: rtl/rrf_seq.sv
module rrf_seq
  import rrf_pkg::*;
#(
  parameter int unsigned PTR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               wide,
  input  logic [PTR_W-1:0]   upper,
  input  logic [PTR_W-1:0]   rd_ptr,
  input  logic               mem_rvalid,
  output logic               mem_req,
  output logic [2*PTR_W-1:0] mem_addr,
  output logic               cap_en,
  output logic [IDX_W-1:0]   cap_idx,
  output logic               adv,
  output logic               busy,
  output logic               done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FIELDS - 1);

  rrf_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  function automatic logic [PTR_W-1:0] slot_ptr(input logic [PTR_W-1:0] base,
                                                input logic [IDX_W-1:0] k,
                                                input logic             w);
    logic [PTR_W-1:0] off;
    off = w ? (PTR_W'(k) << 2) : (PTR_W'(k) << 1);
    return base + off;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q  <= ST_READ;
            idx_q    <= '0;
            mem_req  <= 1'b1;
            mem_addr <= {upper, rd_ptr};
          end
        end
        ST_READ: begin
          if (mem_rvalid) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_ADV;
              mem_req <= 1'b0;
            end else begin
              idx_q    <= idx_q + 1'b1;
              mem_addr <= {upper, slot_ptr(rd_ptr, idx_q + 1'b1, wide)};
            end
          end
        end
        ST_ADV: begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cap_en  = (state_q == ST_READ) && mem_rvalid;
  assign cap_idx = idx_q;
  assign adv     = (state_q == ST_ADV);
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/rrf_ptr_unit.sv
module rrf_ptr_unit
  import rrf_pkg::*;
#(
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  input  logic             busy,
  input  logic             adv,
  input  logic             rp_wr,
  input  logic [PTR_W-1:0] rp_wdata,
  input  logic             exh_clr,
  input  logic [PTR_W-1:0] ring_start,
  input  logic [PTR_W-1:0] ring_end,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             exhausted
);
  localparam logic [PTR_W-1:0] EVEN_MASK  = ~PTR_W'(1);
  localparam logic [PTR_W-1:0] STRIDE_N   = PTR_W'(NUM_FIELDS * 2);
  localparam logic [PTR_W-1:0] STRIDE_W   = PTR_W'(NUM_FIELDS * 4);

  logic [PTR_W-1:0] start_m, end_m, wr_m;
  logic [PTR_W-1:0] stepped, next_ptr;

  always_comb begin
    start_m  = ring_start & EVEN_MASK;
    end_m    = ring_end   & EVEN_MASK;
    wr_m     = wr_ptr     & EVEN_MASK;
    stepped  = rd_ptr + (wide ? STRIDE_W : STRIDE_N);
    next_ptr = (stepped == end_m) ? start_m : stepped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      exhausted <= 1'b0;
    end else if (adv) begin
      rd_ptr <= next_ptr;
      if (next_ptr == wr_m) exhausted <= 1'b1;
    end else if (!busy) begin
      if (rp_wr)   rd_ptr    <= rp_wdata & EVEN_MASK;
      if (exh_clr) exhausted <= 1'b0;
    end
  end
endmodule

// File: rtl/rrf_field_regs.sv
module rrf_field_regs
  import rrf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cap_en,
  input  logic [IDX_W-1:0]             cap_idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM_FIELDS*DATA_W-1:0] fields
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)
        fields[g*DATA_W +: DATA_W] <= '0;
      else if (cap_en && cap_idx == IDX_W'(g))
        fields[g*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/rx_ring_fetch.sv
module rx_ring_fetch
  import rrf_pkg::*;
#(
  parameter int unsigned PTR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_cmd,
  input  logic               exh_clr,
  input  logic               rx_en,
  input  logic               wide_mode,
  input  logic [PTR_W-1:0]   upper_addr,
  input  logic [PTR_W-1:0]   ring_start,
  input  logic [PTR_W-1:0]   ring_end,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic               rp_wr,
  input  logic [PTR_W-1:0]   rp_wdata,
  input  logic               mem_rvalid,
  input  logic [PTR_W-1:0]   mem_rdata,
  output logic               mem_req,
  output logic [2*PTR_W-1:0] mem_addr,
  output logic [PTR_W-1:0]   rd_ptr,
  output logic [2*PTR_W-1:0] buf_addr,
  output logic [2*PTR_W-1:0] buf_words,
  output logic               busy,
  output logic               done,
  output logic               exhausted,
  output logic               rx_ok
);
  logic                        start, cap_en, adv;
  logic [IDX_W-1:0]            cap_idx;
  logic [NUM_FIELDS*PTR_W-1:0] fields;

  assign start = !busy && (fetch_cmd || (exh_clr && exhausted));

  rrf_seq #(.PTR_W(PTR_W)) u_seq (
    .clk, .rst, .start, .wide(wide_mode), .upper(upper_addr), .rd_ptr,
    .mem_rvalid, .mem_req, .mem_addr, .cap_en, .cap_idx, .adv, .busy, .done
  );

  rrf_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk, .rst, .wide(wide_mode), .busy, .adv, .rp_wr, .rp_wdata, .exh_clr,
    .ring_start, .ring_end, .wr_ptr, .rd_ptr, .exhausted
  );

  rrf_field_regs #(.DATA_W(PTR_W)) u_fields (
    .clk, .rst, .cap_en, .cap_idx, .wdata(mem_rdata), .fields
  );

  assign buf_addr  = fields[0 +: 2*PTR_W];
  assign buf_words = fields[2*PTR_W +: 2*PTR_W];
  assign rx_ok     = rx_en && !exhausted;
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker #(
  parameter int unsigned PTR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               mem_req,
  input logic               mem_rvalid,
  input logic [2*PTR_W-1:0] mem_addr,
  input logic [PTR_W-1:0]   rd_ptr,
  input logic               busy,
  input logic               done,
  input logic               exhausted,
  input logic               rx_ok
);
  a_r12_addr_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  a_r2_addr_even: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> $stable(rd_ptr));

  a_r6_exh_on_done: assert property (@(posedge clk) disable iff (rst)
    $rose(exhausted) |-> done);

  a_r10_refuse: assert property (@(posedge clk) disable iff (rst)
    exhausted |-> !rx_ok);

  a_r11_ptr_even: assert property (@(posedge clk) disable iff (rst)
    !rd_ptr[0]);
endmodule

bind rx_ring_fetch rrf_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .mem_addr(mem_addr), .rd_ptr(rd_ptr), .busy(busy), .done(done),
  .exhausted(exhausted), .rx_ok(rx_ok)
);

// File: tb/rx_ring_fetch_tb.sv
module rx_ring_fetch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_cmd = 0, exh_clr = 0, rx_en = 0, wide_mode = 0, rp_wr = 0;
  logic [15:0] upper_addr = 16'h00C4, ring_start = 0, ring_end = 0, wr_ptr = 0, rp_wdata = 0;
  logic        mem_rvalid = 0;
  logic [15:0] mem_rdata = 0;
  logic        mem_req, busy, done, exhausted, rx_ok;
  logic [31:0] mem_addr, buf_addr, buf_words;
  logic [15:0] rd_ptr;

  int checks = 0, failures = 0;
  int lat = 0, wcnt = 0, nlog = 0, dones = 0;
  logic [31:0] alog [4];

  always #2 clk = ~clk;

  rx_ring_fetch u_dut (
    .clk, .rst, .fetch_cmd, .exh_clr, .rx_en, .wide_mode, .upper_addr,
    .ring_start, .ring_end, .wr_ptr, .rp_wr, .rp_wdata, .mem_rvalid, .mem_rdata,
    .mem_req, .mem_addr, .rd_ptr, .buf_addr, .buf_words, .busy, .done,
    .exhausted, .rx_ok
  );

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h3C5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers after lat idle cycles, logs the address it answered
  always @(negedge clk) begin
    if (done) dones++;
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(mem_addr);
        if (nlog < 4) alog[nlog] = mem_addr;
        nlog++;
      end else wcnt++;
    end
  end

  task automatic run_fetch(input bit via_clr);
    nlog = 0;
    @(negedge clk);
    if (via_clr) exh_clr = 1; else fetch_cmd = 1;
    @(negedge clk);
    exh_clr = 0; fetch_cmd = 0;
    for (int t = 0; t < 200; t++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] exp_rp, s;
    logic        exp_exh, via;
    logic [31:0] a [4];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_ptr", 32'(rd_ptr), 0);
    chk("R1 busy/done/req/exh", {28'd0, busy, done, mem_req, exhausted}, 0);
    chk("R1 buf_addr", buf_addr, 0);
    chk("R1 buf_words", buf_words, 0);
    chk("R1 mem_addr", mem_addr, 0);
    chk("R10 rx_ok with rx_en low", 32'(rx_ok), 0);
    rx_en = 1;
    @(negedge clk);
    chk("R10 rx_ok enabled", 32'(rx_ok), 1);
    // R11 odd load
    rp_wr = 1; rp_wdata = 16'h0123;
    @(negedge clk); rp_wr = 0;
    @(negedge clk);
    chk("R11 bit0 cleared", 32'(rd_ptr), 32'h0122);
    // R9 negative: clear while not exhausted
    exh_clr = 1; @(negedge clk); exh_clr = 0;
    repeat (3) @(negedge clk);
    chk("R9 clear when not exhausted", {30'd0, busy, mem_req}, 0);

    for (int w = 0; w < 2; w++) begin
      wide_mode = w[0];
      s = w ? 16'd16 : 16'd8;
      ring_start = 16'h0201;               // bit 0 ignored (R5)
      ring_end   = 16'h0200 + 4 * s;
      wr_ptr     = 16'h0200 + 3 * s + 1;   // bit 0 ignored (R6)
      rp_wr = 1; rp_wdata = 16'h0200;
      @(negedge clk); rp_wr = 0;
      exp_rp = 16'h0200;
      exp_exh = 1'b0;
      for (int i = 0; i < 6; i++) begin
        lat = (i + w) % 3;
        via = exp_exh;
        for (int k = 0; k < 4; k++)
          a[k] = {upper_addr, 16'(exp_rp + k * (w ? 4 : 2))};
        run_fetch(via);
        if (via) exp_exh = 1'b0;
        exp_rp = exp_rp + s;
        if (exp_rp == 16'h0200 + 4 * s) exp_rp = 16'h0200;
        if (exp_rp == 16'h0200 + 3 * s) exp_exh = 1'b1;
        chk("R7 done with busy low", {30'd0, done, busy}, 32'h2);
        chk("R12 four reads", nlog, 4);
        for (int k = 0; k < 4; k++) chk("R2 field address", alog[k], a[k]);
        chk("R3 buf_addr", buf_addr, {memf(a[1]), memf(a[0])});
        chk("R3/R12 buf_words", buf_words, {memf(a[3]), memf(a[2])});
        chk("R4/R5 rd_ptr", 32'(rd_ptr), 32'(exp_rp));
        chk(via ? "R9 clear restarts" : "R6 exhausted", 32'(exhausted), 32'(exp_exh));
        chk("R10 rx_ok", 32'(rx_ok), 32'(!exp_exh));
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 0);
      end
      if (exp_exh) begin
        exh_clr = 1; @(negedge clk); exh_clr = 0;
        repeat (40) @(negedge clk);
      end
    end

    // R8: requests during busy are ignored
    wide_mode = 0; ring_end = 16'hFFF0; wr_ptr = 16'hFFF0;
    rp_wr = 1; rp_wdata = 16'h1000; @(negedge clk); rp_wr = 0;
    @(negedge clk);
    lat = 3;
    dones = 0;
    fetch_cmd = 1; @(negedge clk); fetch_cmd = 0;
    @(negedge clk);
    fetch_cmd = 1; rp_wr = 1; rp_wdata = 16'h0F00; exh_clr = 1;
    @(negedge clk);
    fetch_cmd = 0; rp_wr = 0; exh_clr = 0;
    repeat (60) @(negedge clk);
    chk("R8 single completion", dones, 1);
    chk("R8 rd_ptr not loaded", 32'(rd_ptr), 32'h1008);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule